// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block turns one data-movement instruction of a 16-bit word-addressed machine into a short series of memory transfers. It accepts the instruction word and the already-incremented program counter. It also takes the base-register value and the store-source value, which come from a register file that it steers through a field select. From these it computes the effective address in one of three ways: PC-relative, base plus offset, or through a pointer held in memory. It then drives a request/write-enable/ready handshake toward a memory that may stall for any number of cycles.

Loads and the address-only instruction finish with a register write-back request and a condition-code update. Stores finish with a single write transfer. The pointer forms chain two transfers: the first reads the pointer word and the second uses that word as the address. The address-only form touches no memory and completes in the cycle after acceptance. Instructions of any other opcode are retired at once with no effect. One instruction is in flight at a time, and a start pulse seen while busy is dropped.

Top module: `mem_access_seq`

## Requirements
- R1: For opcodes 0010 (load) and 0011 (store) the access address is `pc_next` plus bits 8..0 of the instruction, sign-extended to 16 bits.
- R2: For opcodes 0110 (load) and 0111 (store) the access address is `base_val` plus bits 5..0 of the instruction, sign-extended. `base_sel` shows bits 8..6 of the instruction in the same cycle.
- R3: For opcodes 1010 (load) and 1011 (store) a read is made first at the PC-relative address of R1. The word it returns is the address of the second and final transfer, so exactly two transfers take place.
- R4: Opcode 1110 writes the PC-relative address of R1 to the register named by bits 11..9. It makes no memory transfer, and `done` rises in the cycle after acceptance.
- R5: A store writes the `store_val` sampled at acceptance, with `mem_we` high on the final transfer only. It raises no write-back.
- R6: A load places the word returned by its final transfer on `wb_data`, with `wb_en` high and `wb_reg` equal to bits 11..9, during the `done` cycle.
- R7: Whenever `wb_en` is high, `cc_nzp` is one-hot. Bit 2 means the written value is negative, bit 1 means it is zero, and bit 0 means it is positive.
- R8: Once raised, `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ready` is seen at a clock edge. Each such edge completes exactly one transfer.
- R9: `done` is a one-cycle pulse. `busy` is high from acceptance through the `done` cycle, and `start` is ignored while `busy` is high.
- R10: An opcode outside the seven above raises `done` in the cycle after acceptance, with no transfer and no write-back.
- R11: After reset the block is idle: `busy`, `done`, `mem_req`, `mem_we` and `wb_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present an instruction; taken only while idle |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Program counter already advanced past the instruction |
| base_val | input | 16 | Value of the register named by `base_sel` |
| store_val | input | 16 | Value to be stored |
| base_sel | output | 3 | Base register number for the register-file read |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| wb_en | output | 1 | Register write-back request |
| wb_reg | output | 3 | Destination register number |
| wb_data | output | 16 | Value to write back |
| cc_nzp | output | 3 | Condition codes of the written value |
| done | output | 1 | Instruction finished (one cycle) |

## Verification
The seven opcodes are run with positive, negative and extreme offsets, which separates a sign-extension fault from an adder or field-select fault. Memory latencies of zero to three wait cycles show whether the request is held and the address kept stable across a stall. A store through a pointer is followed by a load through the same pointer, which proves that the pointer word, and not the first address, steers the final transfer. Returned values of zero, negative and positive tell the three condition codes apart. A start pulse during a stalled load and an unsupported opcode confirm that neither produces a stray transfer or write-back.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

    localparam int DW   = 16;   // data and address width
    localparam int IW   = 16;   // instruction width
    localparam int RSW  = 3;    // register number width

    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_STR = 4'b0111;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_STI = 4'b1011;
    localparam logic [3:0] OPC_LEA = 4'b1110;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PTR,
        SEQ_ACC,
        SEQ_FIN
    } seq_state_e;

    typedef struct packed {
        logic legal;
        logic store;
        logic indirect;
        logic base_mode;
        logic addr_only;
        logic writes_reg;
    } acc_kind_t;

    function automatic logic [2:0] nzp_of(input logic [DW-1:0] v);
        if (v[DW-1])       return 3'b100;
        else if (v == '0)  return 3'b010;
        else               return 3'b001;
    endfunction

endpackage

// File: rtl/memseq_dec.sv
module memseq_dec
    import memseq_pkg::*;
(
    input  logic [3:0] opcode,
    output acc_kind_t  kind
);
    always_comb begin
        kind = '0;
        unique case (opcode)
            OPC_LD:  begin kind.legal = 1'b1; kind.writes_reg = 1'b1; end
            OPC_ST:  begin kind.legal = 1'b1; kind.store = 1'b1; end
            OPC_LDR: begin kind.legal = 1'b1; kind.base_mode = 1'b1; kind.writes_reg = 1'b1; end
            OPC_STR: begin kind.legal = 1'b1; kind.base_mode = 1'b1; kind.store = 1'b1; end
            OPC_LDI: begin kind.legal = 1'b1; kind.indirect = 1'b1; kind.writes_reg = 1'b1; end
            OPC_STI: begin kind.legal = 1'b1; kind.indirect = 1'b1; kind.store = 1'b1; end
            OPC_LEA: begin kind.legal = 1'b1; kind.addr_only = 1'b1; kind.writes_reg = 1'b1; end
            default: kind = '0;
        endcase
    end
endmodule

// File: rtl/memseq_agen.sv
module memseq_agen #(
    parameter int DW    = memseq_pkg::DW,
    parameter int IW    = memseq_pkg::IW,
    parameter int PCOFW = 9,
    parameter int BOFW  = 6
) (
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] pc_next,
    input  logic [DW-1:0] base_val,
    input  logic          base_mode,
    output logic [DW-1:0] ea
);
    localparam int PC_EXT = DW - PCOFW;
    localparam int B_EXT  = DW - BOFW;

    logic [DW-1:0] pc_off;
    logic [DW-1:0] base_off;
    logic [DW-1:0] origin;
    logic [DW-1:0] offset;

    assign pc_off   = {{PC_EXT{instr[PCOFW-1]}}, instr[PCOFW-1:0]};
    assign base_off = {{B_EXT{instr[BOFW-1]}},  instr[BOFW-1:0]};

    // one shared adder, operands chosen by addressing mode
    assign origin = base_mode ? base_val : pc_next;
    assign offset = base_mode ? base_off : pc_off;
    assign ea     = origin + offset;
endmodule

// File: rtl/memseq_seq.sv
module memseq_seq
    import memseq_pkg::*;
#(
    parameter int DW  = memseq_pkg::DW,
    parameter int RSW = memseq_pkg::RSW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  acc_kind_t      kind,
    input  logic [RSW-1:0] dest,
    input  logic [DW-1:0]  ea,
    input  logic [DW-1:0]  store_val,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic           wb_en,
    output logic [RSW-1:0] wb_reg,
    output logic [DW-1:0]  wb_data,
    output logic [2:0]     cc_nzp,
    output logic           done
);
    seq_state_e     state_q;
    acc_kind_t      kind_q;
    logic [DW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  result_q;
    logic [RSW-1:0] dest_q;
    logic           accept;

    assign accept = start && (state_q == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            kind_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            result_q <= '0;
            dest_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    kind_q   <= kind;
                    addr_q   <= ea;
                    wdata_q  <= store_val;
                    result_q <= ea;
                    dest_q   <= dest;
                    if (!kind.legal || kind.addr_only) state_q <= SEQ_FIN;
                    else if (kind.indirect)            state_q <= SEQ_PTR;
                    else                               state_q <= SEQ_ACC;
                end
                SEQ_PTR: if (mem_ready) begin
                    addr_q  <= mem_rdata;
                    state_q <= SEQ_ACC;
                end
                SEQ_ACC: if (mem_ready) begin
                    if (!kind_q.store) result_q <= mem_rdata;
                    state_q <= SEQ_FIN;
                end
                SEQ_FIN: state_q <= SEQ_IDLE;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != SEQ_IDLE);
    assign mem_req   = (state_q == SEQ_PTR) || (state_q == SEQ_ACC);
    assign mem_we    = (state_q == SEQ_ACC) && kind_q.store;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign done      = (state_q == SEQ_FIN);
    assign wb_en     = done && kind_q.legal && kind_q.writes_reg;
    assign wb_reg    = dest_q;
    assign wb_data   = result_q;
    assign cc_nzp    = nzp_of(result_q);

    // R8: request and its attributes hold until ready
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R3: the pointer word becomes the final address
    a_r3_ptr_chain: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_PTR) && mem_ready |=> mem_req && (mem_addr == $past(mem_rdata)));

    // R5: a completed write is the last transfer of its instruction
    a_r5_write_last: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ready |=> done && !wb_en);

    // R4: address-only form retires next cycle with a write-back
    a_r4_lea_fast: assert property (@(posedge clk) disable iff (rst)
        accept && kind.legal && kind.addr_only |=> done && wb_en && !mem_req);

    // R10: unsupported opcode retires next cycle silently
    a_r10_illegal: assert property (@(posedge clk) disable iff (rst)
        accept && !kind.legal |=> done && !wb_en && !mem_req);

    // R9: one-cycle done, busy holds until done
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);

    // R6 / R7: write-back only at done, codes one-hot
    a_r6_wb_at_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
    a_r7_cc_onehot: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ($countones(cc_nzp) == 1));
endmodule

// File: rtl/mem_access_seq.sv
module mem_access_seq
    import memseq_pkg::*;
#(
    parameter int DW  = memseq_pkg::DW,
    parameter int IW  = memseq_pkg::IW,
    parameter int RSW = memseq_pkg::RSW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [IW-1:0]  instr,
    input  logic [DW-1:0]  pc_next,
    input  logic [DW-1:0]  base_val,
    input  logic [DW-1:0]  store_val,
    output logic [RSW-1:0] base_sel,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ready,
    input  logic [DW-1:0]  mem_rdata,
    output logic           wb_en,
    output logic [RSW-1:0] wb_reg,
    output logic [DW-1:0]  wb_data,
    output logic [2:0]     cc_nzp,
    output logic           done
);
    localparam int OPC_LSB  = IW - 4;
    localparam int DEST_LSB = OPC_LSB - RSW;
    localparam int BASE_LSB = DEST_LSB - RSW;

    acc_kind_t     kind;
    logic [DW-1:0] ea;

    assign base_sel = instr[BASE_LSB +: RSW];

    memseq_dec u_dec (
        .opcode (instr[OPC_LSB +: 4]),
        .kind   (kind)
    );

    memseq_agen #(.DW(DW), .IW(IW)) u_agen (
        .instr     (instr),
        .pc_next   (pc_next),
        .base_val  (base_val),
        .base_mode (kind.base_mode),
        .ea        (ea)
    );

    memseq_seq #(.DW(DW), .RSW(RSW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .kind      (kind),
        .dest      (instr[DEST_LSB +: RSW]),
        .ea        (ea),
        .store_val (store_val),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .wb_data   (wb_data),
        .cc_nzp    (cc_nzp),
        .done      (done)
    );
endmodule

// File: tb/test_mem_access_seq.sv
`timescale 1ns/1ps
module test_mem_access_seq;

    localparam int K_LD  = 0;
    localparam int K_ST  = 1;
    localparam int K_LEA = 2;

    typedef struct packed {
        logic [15:0] instr;
        logic [15:0] pc;
        logic [15:0] base;
        logic [15:0] sval;
        logic [3:0]  lat;
        logic [1:0]  kind;
        logic [15:0] ptr;      // nonzero: pointer form, first read address
        logic [15:0] addr;     // final address, or LEA result
    } vec_t;

    localparam int NV = 9;
    localparam logic [101:0] VEC [NV] = '{
        {16'h2605, 16'h3010, 16'h0000, 16'h0000, 4'd0, 2'd0, 16'h0000, 16'h3015}, // R1 +5
        {16'h23FD, 16'h3010, 16'h0000, 16'h0000, 4'd2, 2'd0, 16'h0000, 16'h300D}, // R1 -3
        {16'h3A20, 16'h3010, 16'h0000, 16'hBEEF, 4'd1, 2'd1, 16'h0000, 16'h3030}, // R1/R5 store
        {16'h65BF, 16'h3010, 16'h4080, 16'h0000, 4'd0, 2'd0, 16'h0000, 16'h407F}, // R2 -1
        {16'h7E5F, 16'h3010, 16'h5000, 16'h0000, 4'd3, 2'd1, 16'h0000, 16'h501F}, // R2 +31 store 0
        {16'hE900, 16'h3010, 16'h0000, 16'h0000, 4'd0, 2'd2, 16'h0000, 16'h2F10}, // R4 -256
        {16'hB230, 16'h3010, 16'h0000, 16'h8001, 4'd1, 2'd1, 16'h3040, 16'h6085}, // R3 store via ptr
        {16'hA030, 16'h3010, 16'h0000, 16'h0000, 4'd2, 2'd0, 16'h3040, 16'h6085}, // R3 load via ptr
        {16'h665F, 16'h3010, 16'h5000, 16'h0000, 4'd1, 2'd0, 16'h0000, 16'h501F}  // R7 zero
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0, pc_next = '0, base_val = '0, store_val = '0;
    logic [2:0]  base_sel;
    logic        busy, mem_req, mem_we, mem_ready, wb_en, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, wb_data;
    logic [2:0]  wb_reg, cc_nzp;

    always #4 clk = ~clk;   // 125 MHz

    mem_access_seq i_mem_access_seq (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_next(pc_next),
        .base_val(base_val), .store_val(store_val), .base_sel(base_sel),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data), .cc_nzp(cc_nzp),
        .done(done)
    );

    // memory model: 256 words indexed by the low address byte
    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    int lat = 0;
    int cnt = 0;
    logic rdy = 1'b0;
    logic [15:0] rdat = '0;
    assign mem_ready = rdy;
    assign mem_rdata = rdat;

    int nlog = 0;
    int nwr  = 0;
    logic [15:0] log_addr [4];
    int hold_err = 0;
    logic prev_pend = 1'b0;
    logic [15:0] prev_addr = '0;

    always @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0; cnt <= 0;
        end else if (rdy) begin
            rdy <= 1'b0; cnt <= 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                rdy  <= 1'b1;
                rdat <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end else cnt <= cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_err = hold_err + 1;
            if (mem_req && rdy) begin
                if (nlog < 4) log_addr[nlog] = mem_addr;
                nlog = nlog + 1;
                if (mem_we) nwr = nwr + 1;
            end
        end
        prev_pend = !rst && mem_req && !rdy;
        prev_addr = mem_addr;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_nzp(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic launch(input logic [15:0] i, input logic [15:0] p, input logic [15:0] b,
                          input logic [15:0] s, input int l);
        @(negedge clk);
        lat = l; nlog = 0; nwr = 0;
        instr = i; pc_next = p; base_val = b; store_val = s; start = 1'b1;
        #1;
        chk(base_sel == i[8:6], "R2 base_sel", base_sel, i[8:6]);
        @(negedge clk);
        start = 1'b0; instr = '0; pc_next = '0; base_val = '0; store_val = '0;
    endtask

    task automatic wait_done(output int waits);
        waits = 0;
        while (!done && waits < 100) begin
            @(negedge clk);
            waits++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        int w;
        for (int k = 0; k < 256; k++) begin
            mem[k] = 16'h1200 + 16'(k);
        end
        mem[8'h40] = 16'h6085;
        for (int k = 0; k < 256; k++) ref_mem[k] = mem[k];

        repeat (3) @(negedge clk);
        // R11: idle after reset
        chk(!busy && !done && !mem_req && !mem_we && !wb_en, "R11 reset idle",
            {busy, done, mem_req, mem_we, wb_en}, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] exp_d;
            v = vec_t'(VEC[i]);
            launch(v.instr, v.pc, v.base, v.sval, int'(v.lat));
            wait_done(w);
            chk(done, "R9 done seen", done, 1);
            chk(busy, "R9 busy in done cycle", busy, 1);
            if (v.kind == 2'(K_LEA)) begin
                chk(w == 0, "R4 one-cycle latency", w, 0);
                chk(nlog == 0, "R4 no transfer", nlog, 0);
            end else if (v.ptr != 0) begin
                chk(nlog == 2, "R3 two transfers", nlog, 2);
                chk(log_addr[0] == v.ptr, "R3 pointer address", log_addr[0], v.ptr);
                chk(log_addr[1] == v.addr, "R3 final address", log_addr[1], v.addr);
            end else begin
                chk(nlog == 1, "R8 one transfer", nlog, 1);
                chk(log_addr[0] == v.addr, "R1/R2 address", log_addr[0], v.addr);
            end
            if (v.kind == 2'(K_ST)) begin
                ref_mem[v.addr[7:0]] = v.sval;
                chk(nwr == 1, "R5 single write", nwr, 1);
                chk(mem[v.addr[7:0]] == v.sval, "R5 stored value", mem[v.addr[7:0]], v.sval);
                chk(!wb_en, "R5 no write-back", wb_en, 0);
            end else begin
                exp_d = (v.kind == 2'(K_LEA)) ? v.addr : ref_mem[v.addr[7:0]];
                chk(nwr == 0, "R6 no write on load", nwr, 0);
                chk(wb_en, "R6 write-back", wb_en, 1);
                chk(wb_reg == v.instr[11:9], "R6 dest reg", wb_reg, v.instr[11:9]);
                chk(wb_data == exp_d, "R6 data", wb_data, exp_d);
                chk(cc_nzp == exp_nzp(exp_d), "R7 codes", cc_nzp, exp_nzp(exp_d));
            end
            @(negedge clk);
            chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
        end

        // R10: unsupported opcode 0001
        launch(16'h1234, 16'h3010, 16'h0, 16'h0, 0);
        wait_done(w);
        chk(w == 0 && done, "R10 retires next cycle", w, 0);
        chk(!wb_en, "R10 no write-back", wb_en, 0);
        chk(nlog == 0, "R10 no transfer", nlog, 0);

        // R9: start while busy is dropped
        begin
            int ndone;
            logic [15:0] got;
            launch(16'h2605, 16'h3010, 16'h0, 16'h0, 3);
            instr = 16'hE900; pc_next = 16'h3010; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            ndone = 0; got = '0;
            for (int c = 0; c < 14; c++) begin
                if (done) begin ndone++; got = wb_data; end
                @(negedge clk);
            end
            chk(ndone == 1, "R9 busy start ignored", ndone, 1);
            chk(got == ref_mem[8'h15], "R9 load result kept", got, ref_mem[8'h15]);
            chk(nlog == 1, "R9 no extra transfer", nlog, 1);
        end

        chk(hold_err == 0, "R8 request held", hold_err, 0);
        finish_run();
    end
endmodule